// File: doc/BRIEF.md
# Coincidence Trigger Decision Unit

This block is the central decision point of a trigger system. Per-channel detectors upstream report trigger candidates. Each candidate is tagged as either a primary pulse (type 1) or a secondary pulse (type 2). The block stamps every candidate with its own arrival cycle. It then decides, once per clock, whether the whole detector should be read out, and it emits an accept record. The record carries the active mode, a running accept count, and a timestamp split into a fine part and a coarse part.

The mode input selects one of four behaviours:
- **External:** only the external trigger input fires.
- **Internal simple:** a type 1 coincidence alone fires. A coincidence means more than a set number of candidates whose arrivals all fall inside a set window.
- **Internal double:** a type 1 coincidence arms a second stage. That stage fires on a type 2 coincidence that arrives within a bounded delay.
- **Calibration:** either the external or the internal simple path may fire.

After each accept, a holdoff period enforces the maximum trigger rate, and the candidate history is dropped. The recorded timestamp is moved back by a pre-trigger offset so that readout can start before the decision.

Top module: `ctd_trigger_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `acc_valid` is 0, `acc_count` is 0 and the recorded coarse and fine times are 0.
- R2: With `cfg_mode` = 0 (external), `ext_trig` high in a cycle gives `acc_valid` high for one cycle in the next cycle. Candidates of either type never cause an accept in this mode.
- R3: With `cfg_mode` = 1 (simple), an accept is issued in the cycle after the latest type 1 candidate arrives, when more than `cfg_n1` type 1 candidates have arrival cycles that differ by less than `cfg_win1`. Exactly `cfg_n1` candidates, or a spread of `cfg_win1` cycles or more, give no accept.
- R4: With `cfg_mode` = 2 (double), a type 1 coincidence only arms the unit. The accept comes one cycle after the type 2 candidate that completes more than `cfg_n2` type 2 candidates spread less than `cfg_win2` apart.
- R5: In double mode, the arming cycle a and the last type 2 arrival cycle y must satisfy y − a < `cfg_max_gap`. Otherwise the unit drops back to searching for type 1 without an accept.
- R6: With `cfg_mode` = 3 (calibration), both `ext_trig` and a type 1 coincidence produce accepts, and type 2 candidates alone do not.
- R7: After an accept decided in cycle d, no accept is decided in cycles d+1 to d+`cfg_holdoff`. Candidates and `ext_trig` in those cycles are ignored.
- R8: Arming in double mode and every accept discard all stored candidates, including the ones arriving in that same cycle.
- R9: `acc_count` rises by one on each accept, wraps to 0 after its maximum value, and first reads 1.
- R10: The accept record time {`acc_coarse`,`acc_fine`} equals the number of cycles since reset at the decision cycle, minus `cfg_pretrig`, modulo 2^(CT_W+FT_W). The coarse part counts wraps of the fine part.
- R11: `acc_mode` holds the `cfg_mode` of the decision cycle. All record outputs stay unchanged between accepts.
- R12: In double mode, type 2 candidates that arrive before or together with the arming are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 0 external, 1 simple, 2 double, 3 calibration |
| cfg_n1 | input | NB_W | Type 1 count that must be exceeded |
| cfg_n2 | input | NB_W | Type 2 count that must be exceeded |
| cfg_win1 | input | AGE_W | Type 1 coincidence window in cycles |
| cfg_win2 | input | AGE_W | Type 2 coincidence window in cycles |
| cfg_max_gap | input | GAP_W | Maximum cycles from arming to type 2 coincidence |
| cfg_holdoff | input | HOLD_W | Cycles blocked after an accept |
| cfg_pretrig | input | FT_W | Offset subtracted from the record time |
| cand1_valid | input | 1 | Type 1 candidate this cycle |
| cand2_valid | input | 1 | Type 2 candidate this cycle |
| ext_trig | input | 1 | External trigger request |
| acc_valid | output | 1 | Accept pulse |
| acc_mode | output | 2 | Mode of the last accept |
| acc_count | output | CNT_W | Running accept count |
| acc_coarse | output | CT_W | Coarse time of the last accept |
| acc_fine | output | FT_W | Fine time of the last accept |

## Verification
The bench drives candidate trains whose arrival spread sits one cycle inside and one cycle outside the window. A window compare that is off by one would then fire one case too many or one too few. It places the type 2 coincidence exactly one cycle before and exactly at the arming deadline, to catch an inclusive gap test. It also sends type 2 pulses ahead of the arming, which only a design that failed to clear that history would count. Continuous external requests under holdoff, bursts that outlive an accept, and a pre-trigger larger than the elapsed time show up, respectively, as extra accepts, repeated accepts from stale candidates, and timestamps that fail to wrap.

// File: rtl/ctd_pkg.sv
package ctd_pkg;

    typedef enum logic [1:0] {
        MODE_EXT    = 2'd0,
        MODE_SIMPLE = 2'd1,
        MODE_DOUBLE = 2'd2,
        MODE_CALIB  = 2'd3
    } trig_mode_e;

    typedef enum logic {
        ST_SEEK1 = 1'b0,
        ST_SEEK2 = 1'b1
    } stage_e;

endpackage

// File: rtl/ctd_cand_queue.sv
module ctd_cand_queue #(
    parameter int DEPTH = 8,
    parameter int AGE_W = 10,
    localparam int NB_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             clear,
    input  logic [AGE_W-1:0] win,
    output logic [NB_W-1:0]  live_cnt
);

    typedef struct packed {
        logic             vld;
        logic [AGE_W-1:0] age;
    } slot_t;

    slot_t [DEPTH-1:0] slot_q, slot_d, aged;
    logic  [DEPTH-1:0] live;

    // every slot ages by one per cycle, saturating so old entries stay dead
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_comb begin
                aged[g] = slot_q[g];
                if (slot_q[g].age != '1) begin
                    aged[g].age = slot_q[g].age + 1'b1;
                end
            end
            assign live[g] = slot_q[g].vld && (slot_q[g].age < win);
        end
    endgenerate

    always_comb begin
        slot_d = aged;
        if (clear) begin
            slot_d = '0;
        end else if (push) begin
            for (int i = DEPTH - 1; i > 0; i--) begin
                slot_d[i] = aged[i-1];
            end
            slot_d[0] = '{vld: 1'b1, age: '0};
        end
    end

    always_comb begin
        live_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            live_cnt = live_cnt + NB_W'(live[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

endmodule

// File: rtl/ctd_timebase.sv
module ctd_timebase #(
    parameter int FT_W = 12,
    parameter int CT_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [FT_W-1:0] fine,
    output logic [CT_W-1:0] coarse
);

    typedef struct packed {
        logic [CT_W-1:0] coarse;
        logic [FT_W-1:0] fine;
    } tb_t;

    tb_t tb_q, tb_d;

    always_comb begin
        tb_d      = tb_q;
        tb_d.fine = tb_q.fine + 1'b1;
        if (&tb_q.fine) begin
            tb_d.coarse = tb_q.coarse + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_q <= '0;
        end else begin
            tb_q <= tb_d;
        end
    end

    assign fine   = tb_q.fine;
    assign coarse = tb_q.coarse;

endmodule

// File: rtl/ctd_trigger_unit.sv
module ctd_trigger_unit
    import ctd_pkg::*;
#(
    parameter int FT_W   = 12,
    parameter int CT_W   = 20,
    parameter int CNT_W  = 16,
    parameter int DEPTH  = 8,
    parameter int AGE_W  = 10,
    parameter int GAP_W  = 16,
    parameter int HOLD_W = 16,
    localparam int NB_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [NB_W-1:0]   cfg_n1,
    input  logic [NB_W-1:0]   cfg_n2,
    input  logic [AGE_W-1:0]  cfg_win1,
    input  logic [AGE_W-1:0]  cfg_win2,
    input  logic [GAP_W-1:0]  cfg_max_gap,
    input  logic [HOLD_W-1:0] cfg_holdoff,
    input  logic [FT_W-1:0]   cfg_pretrig,
    input  logic              cand1_valid,
    input  logic              cand2_valid,
    input  logic              ext_trig,
    output logic              acc_valid,
    output logic [1:0]        acc_mode,
    output logic [CNT_W-1:0]  acc_count,
    output logic [CT_W-1:0]   acc_coarse,
    output logic [FT_W-1:0]   acc_fine
);

    localparam int TIME_W = CT_W + FT_W;

    typedef struct packed {
        stage_e            stage;
        logic [GAP_W-1:0]  gap;
        logic [HOLD_W-1:0] hold;
        logic [CNT_W-1:0]  cnt;
        logic              acc_vld;
        logic [1:0]        acc_mode;
        logic [TIME_W-1:0] acc_time;
    } state_t;

    state_t           st_q, st_d;
    logic [NB_W-1:0]  live1, live2;
    logic [FT_W-1:0]  fine;
    logic [CT_W-1:0]  coarse;
    logic             clr;
    logic             fire, arm, blocked, hit1, hit2, in_gap;
    trig_mode_e       mode;

    ctd_timebase #(.FT_W(FT_W), .CT_W(CT_W)) u_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .fine   (fine),
        .coarse (coarse)
    );

    ctd_cand_queue #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_queue1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (cand1_valid),
        .clear    (clr),
        .win      (cfg_win1),
        .live_cnt (live1)
    );

    ctd_cand_queue #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_queue2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (cand2_valid),
        .clear    (clr),
        .win      (cfg_win2),
        .live_cnt (live2)
    );

    always_comb begin
        st_d         = st_q;
        st_d.acc_vld = 1'b0;
        mode         = trig_mode_e'(cfg_mode);
        blocked      = |st_q.hold;
        hit1         = live1 > cfg_n1;
        hit2         = live2 > cfg_n2;
        in_gap       = st_q.gap < cfg_max_gap;

        fire = 1'b0;
        if (!blocked) begin
            unique case (mode)
                MODE_EXT:    fire = ext_trig;
                MODE_SIMPLE: fire = hit1;
                MODE_DOUBLE: fire = (st_q.stage == ST_SEEK2) && hit2 && in_gap;
                MODE_CALIB:  fire = ext_trig || hit1;
            endcase
        end

        arm = (mode == MODE_DOUBLE) && !blocked && (st_q.stage == ST_SEEK1) && hit1;

        // stage sequencing for the two-step coincidence
        if (mode != MODE_DOUBLE || fire) begin
            st_d.stage = ST_SEEK1;
            st_d.gap   = '0;
        end else if (blocked) begin
            st_d.stage = st_q.stage;
        end else if (st_q.stage == ST_SEEK1) begin
            if (hit1) begin
                st_d.stage = ST_SEEK2;
                st_d.gap   = '0;
            end
        end else if (!in_gap) begin
            st_d.stage = ST_SEEK1;
            st_d.gap   = '0;
        end else if (st_q.gap != '1) begin
            st_d.gap = st_q.gap + 1'b1;
        end

        // rate limit
        if (fire) begin
            st_d.hold = cfg_holdoff;
        end else if (blocked) begin
            st_d.hold = st_q.hold - 1'b1;
        end

        if (fire) begin
            st_d.cnt      = st_q.cnt + 1'b1;
            st_d.acc_vld  = 1'b1;
            st_d.acc_mode = cfg_mode;
            st_d.acc_time = {coarse, fine} - TIME_W'(cfg_pretrig);
        end

        clr = fire || blocked || arm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_valid  = st_q.acc_vld;
    assign acc_mode   = st_q.acc_mode;
    assign acc_count  = st_q.cnt;
    assign acc_coarse = st_q.acc_time[TIME_W-1:FT_W];
    assign acc_fine   = st_q.acc_time[FT_W-1:0];

endmodule

// File: rtl/ctd_trigger_unit_chk.sv
module ctd_trigger_unit_chk #(
    parameter int FT_W   = 12,
    parameter int CT_W   = 20,
    parameter int CNT_W  = 16,
    parameter int HOLD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_mode,
    input logic [HOLD_W-1:0] cfg_holdoff,
    input logic [FT_W-1:0]   cfg_pretrig,
    input logic              ext_trig,
    input logic              acc_valid,
    input logic [1:0]        acc_mode,
    input logic [CNT_W-1:0]  acc_count,
    input logic [CT_W-1:0]   acc_coarse,
    input logic [FT_W-1:0]   acc_fine
);

    localparam int TIME_W = CT_W + FT_W;

    logic [CNT_W-1:0]  last_cnt;
    logic [HOLD_W-1:0] hold_prev, hold_sh;
    logic [TIME_W-1:0] tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_cnt  <= '0;
            hold_prev <= '0;
            hold_sh   <= '0;
            tick_q    <= '0;
        end else begin
            tick_q    <= tick_q + 1'b1;
            hold_prev <= cfg_holdoff;
            if (acc_valid) begin
                last_cnt <= acc_count;
                hold_sh  <= hold_prev;
            end else if (hold_sh != '0) begin
                hold_sh <= hold_sh - 1'b1;
            end
        end
    end

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> acc_count == last_cnt + 1'b1);

    // R7
    holdoff_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> hold_sh == '0);

    // R11
    mode_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> acc_mode == $past(cfg_mode));

    // R2
    ext_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_mode == 2'd0) |-> $past(ext_trig));

    // R10
    stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> {acc_coarse, acc_fine} == tick_q - 1'b1 - TIME_W'($past(cfg_pretrig)));

    // R11
    record_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> ($stable(acc_count) && $stable(acc_coarse) && $stable(acc_fine) && $stable(acc_mode)));

endmodule

bind ctd_trigger_unit ctd_trigger_unit_chk #(
    .FT_W(FT_W), .CT_W(CT_W), .CNT_W(CNT_W), .HOLD_W(HOLD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_mode    (cfg_mode),
    .cfg_holdoff (cfg_holdoff),
    .cfg_pretrig (cfg_pretrig),
    .ext_trig    (ext_trig),
    .acc_valid   (acc_valid),
    .acc_mode    (acc_mode),
    .acc_count   (acc_count),
    .acc_coarse  (acc_coarse),
    .acc_fine    (acc_fine)
);

// File: tb/ctd_trigger_unit_bench.sv
`timescale 1ns/1ps
module ctd_trigger_unit_bench;

    localparam int FT_W = 6, CT_W = 10, CNT_W = 4, DEPTH = 8;
    localparam int AGE_W = 8, GAP_W = 10, HOLD_W = 8;
    localparam int TMASK = (1 << (FT_W + CT_W)) - 1;
    localparam int GSAT  = (1 << GAP_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]        cfg_mode = '0;
    logic [3:0]        cfg_n1 = '0, cfg_n2 = '0;
    logic [AGE_W-1:0]  cfg_win1 = '0, cfg_win2 = '0;
    logic [GAP_W-1:0]  cfg_max_gap = '0;
    logic [HOLD_W-1:0] cfg_holdoff = '0;
    logic [FT_W-1:0]   cfg_pretrig = '0;
    logic cand1 = 1'b0, cand2 = 1'b0, ext_trig = 1'b0;
    logic              acc_valid;
    logic [1:0]        acc_mode;
    logic [CNT_W-1:0]  acc_count;
    logic [CT_W-1:0]   acc_coarse;
    logic [FT_W-1:0]   acc_fine;

    always #4 clk = ~clk;

    ctd_trigger_unit #(
        .FT_W(FT_W), .CT_W(CT_W), .CNT_W(CNT_W), .DEPTH(DEPTH),
        .AGE_W(AGE_W), .GAP_W(GAP_W), .HOLD_W(HOLD_W)
    ) u_ctd_trigger_unit (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_n1(cfg_n1), .cfg_n2(cfg_n2),
        .cfg_win1(cfg_win1), .cfg_win2(cfg_win2), .cfg_max_gap(cfg_max_gap),
        .cfg_holdoff(cfg_holdoff), .cfg_pretrig(cfg_pretrig), .cand1_valid(cand1),
        .cand2_valid(cand2), .ext_trig(ext_trig), .acc_valid(acc_valid), .acc_mode(acc_mode),
        .acc_count(acc_count), .acc_coarse(acc_coarse), .acc_fine(acc_fine)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0, n_acc = 0;
    int q1[$], q2[$];
    int m_stage = 0, m_gap = 0, m_hold = 0, m_cnt = 0;
    int e_vld = 0, e_mode = 0, e_cnt = 0, e_time = 0;

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // expected behaviour for the cycle whose inputs are currently driven
    task automatic model_step();
        int l1, l2;
        bit h1, h2, blk, fire, arm;
        l1 = 0; l2 = 0;
        foreach (q1[i]) if (cyc - q1[i] - 1 < int'(cfg_win1)) l1++;
        foreach (q2[i]) if (cyc - q2[i] - 1 < int'(cfg_win2)) l2++;
        h1 = l1 > int'(cfg_n1);
        h2 = l2 > int'(cfg_n2);
        blk = m_hold != 0;
        fire = 1'b0;
        if (!blk) begin
            case (cfg_mode)
                2'd0: fire = ext_trig;
                2'd1: fire = h1;
                2'd2: fire = (m_stage == 1) && h2 && (m_gap < int'(cfg_max_gap));
                default: fire = ext_trig || h1;
            endcase
        end
        arm = (cfg_mode == 2'd2) && !blk && (m_stage == 0) && h1;
        if (cfg_mode != 2'd2 || fire) begin
            m_stage = 0; m_gap = 0;
        end else if (!blk) begin
            if (m_stage == 0) begin
                if (h1) begin m_stage = 1; m_gap = 0; end
            end else if (m_gap >= int'(cfg_max_gap)) begin
                m_stage = 0; m_gap = 0;
            end else if (m_gap < GSAT) begin
                m_gap++;
            end
        end
        if (fire) m_hold = int'(cfg_holdoff);
        else if (blk) m_hold--;
        if (fire || blk || arm) begin
            q1.delete(); q2.delete();
        end else begin
            if (cand1) begin q1.push_back(cyc); if (q1.size() > DEPTH) void'(q1.pop_front()); end
            if (cand2) begin q2.push_back(cyc); if (q2.size() > DEPTH) void'(q2.pop_front()); end
        end
        e_vld = fire;
        if (fire) begin
            m_cnt  = (m_cnt + 1) % (1 << CNT_W);
            e_cnt  = m_cnt;
            e_mode = int'(cfg_mode);
            e_time = (cyc - int'(cfg_pretrig)) & TMASK;
        end
    endtask

    task automatic tick(string tag);
        int act, exp;
        model_step();
        @(posedge clk);
        @(negedge clk);
        cyc++;
        if (acc_valid) n_acc++;
        act = {acc_valid, acc_mode, acc_count, acc_coarse, acc_fine};
        exp = (e_vld << 22) | (e_mode << 20) | (e_cnt << 16) | e_time;
        check({tag, " record R11"}, act, exp);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic burst(int typ, int cnt, int step, string tag);
        for (int i = 0; i < cnt; i++) begin
            if (typ == 1) cand1 = 1'b1; else cand2 = 1'b1;
            tick(tag);
            cand1 = 1'b0; cand2 = 1'b0;
            for (int k = 1; k < step; k++) tick(tag);
        end
    endtask

    int base;

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd917));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 state under reset
        check("R1 valid", int'(acc_valid), 0);
        check("R1 count", int'(acc_count), 0);
        check("R1 time", int'({acc_coarse, acc_fine}), 0);
        rst_n = 1'b1;

        // R10 pre-trigger larger than elapsed time wraps the stamp
        cfg_mode = 2'd0; cfg_pretrig = 6'd20;
        idle(3, "R10");
        ext_trig = 1'b1; tick("R2"); ext_trig = 1'b0;
        check("R10 coarse", int'(acc_coarse), ((3 - 20) & TMASK) >> FT_W);
        check("R10 fine", int'(acc_fine), (3 - 20) & 63);
        check("R9 first count", int'(acc_count), 1);
        idle(66, "R10");
        cfg_pretrig = 6'd2;
        ext_trig = 1'b1; tick("R10"); ext_trig = 1'b0;
        check("R10 rollover coarse", int'(acc_coarse), 1);
        check("R10 rollover fine", int'(acc_fine), 4);

        // R2 candidates ignored in external mode
        cfg_n1 = 4'd1; cfg_win1 = 8'd30; base = n_acc;
        burst(1, 4, 1, "R2"); idle(20, "R2");
        check("R2 cand ignored", n_acc - base, 0);

        // R3 threshold and window edges
        cfg_mode = 2'd1; cfg_n1 = 4'd2; cfg_win1 = 8'd10; base = n_acc;
        burst(1, 2, 1, "R3"); idle(20, "R3");
        check("R3 exactly N1", n_acc - base, 0);
        base = n_acc; burst(1, 3, 4, "R3"); idle(20, "R3");
        check("R3 spread 8", n_acc - base, 1);
        cfg_n1 = 4'd1; base = n_acc; burst(1, 2, 9, "R3"); idle(20, "R3");
        check("R3 spread win-1", n_acc - base, 1);
        base = n_acc; burst(1, 2, 10, "R3"); idle(20, "R3");
        check("R3 spread win", n_acc - base, 0);

        // R8 stale candidates dropped at accept
        cfg_win1 = 8'd20; base = n_acc; burst(1, 3, 1, "R8"); idle(30, "R8");
        check("R8 cleared", n_acc - base, 1);

        // R4 R5 R12 double mode
        cfg_mode = 2'd2; cfg_n1 = 4'd1; cfg_win1 = 8'd8; cfg_n2 = 4'd1;
        cfg_win2 = 8'd8; cfg_max_gap = 10'd30;
        idle(10, "R4");
        base = n_acc; burst(2, 2, 1, "R12"); burst(1, 2, 1, "R12"); idle(40, "R12");
        check("R12 early type2", n_acc - base, 0);
        base = n_acc; burst(1, 2, 1, "R4"); idle(5, "R4"); burst(2, 2, 1, "R4"); idle(40, "R4");
        check("R4 double accept", n_acc - base, 1);
        base = n_acc; burst(1, 2, 1, "R5"); idle(28, "R5"); burst(2, 2, 1, "R5"); idle(40, "R5");
        check("R5 gap max-1", n_acc - base, 1);
        base = n_acc; burst(1, 2, 1, "R5"); idle(29, "R5"); burst(2, 2, 1, "R5"); idle(40, "R5");
        check("R5 gap at max", n_acc - base, 0);

        // R6 calibration
        cfg_mode = 2'd3; base = n_acc;
        ext_trig = 1'b1; tick("R6"); ext_trig = 1'b0; idle(10, "R6");
        burst(1, 2, 1, "R6"); idle(20, "R6");
        burst(2, 3, 1, "R6"); idle(20, "R6");
        check("R6 both sources", n_acc - base, 2);

        // R7 holdoff
        cfg_mode = 2'd0; cfg_holdoff = 8'd5; base = n_acc;
        ext_trig = 1'b1; idle(30, "R7"); ext_trig = 1'b0; idle(10, "R7");
        check("R7 ext rate", n_acc - base, 5);
        cfg_mode = 2'd1; cfg_holdoff = 8'd10; cfg_win1 = 8'd20; base = n_acc;
        burst(1, 2, 1, "R7"); burst(1, 2, 1, "R7"); idle(40, "R7");
        check("R7 cand ignored", n_acc - base, 1);

        // R9 wrap
        cfg_mode = 2'd0; cfg_holdoff = 8'd0; base = int'(acc_count);
        ext_trig = 1'b1; idle(20, "R9"); ext_trig = 1'b0; idle(2, "R9");
        check("R9 wrap", int'(acc_count), (base + 20) % 16);

        // random segments in all modes
        for (int s = 0; s < 12; s++) begin
            cfg_mode    = 2'($urandom % 4);
            cfg_n1      = 4'($urandom % 3);
            cfg_n2      = 4'($urandom % 3);
            cfg_win1    = 8'(4 + $urandom % 20);
            cfg_win2    = 8'(4 + $urandom % 20);
            cfg_max_gap = 10'(10 + $urandom % 40);
            cfg_holdoff = 8'($urandom % 8);
            cfg_pretrig = 6'($urandom % 64);
            for (int c = 0; c < 400; c++) begin
                cand1    = ($urandom % 5) == 0;
                cand2    = ($urandom % 5) == 0;
                ext_trig = ($urandom % 40) == 0;
                tick("R3 R4 R6 random");
            end
            cand1 = 1'b0; cand2 = 1'b0; ext_trig = 1'b0;
        end
        idle(5, "R11");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule